// File: doc/BRIEF.md
# Event-Triggered Audio DMA Channel

This block is one channel of an audio DMA engine. Software loads a source block address, a destination block address and a block count, then sets a request bit. Each address carries a two-bit target-space code. Once armed, the channel waits for a selected hardware trigger, or starts at once. It then moves the requested number of 128-byte blocks from system memory into the audio write FIFO, one 32-bit beat at a time. The memory-read side and the FIFO-write side each have a valid/ready handshake.

A three-bit status output shows where the request stands. One encoding is idle, and three encodings are terminal: finished, cancelled or rejected. A one-clock completion pulse feeds the interrupt logic. A global clear input aborts a request that is armed or running. The aborted request still raises the completion pulse, as though it had finished normally.

Top module: `audio_dma_channel`

## Requirements
- R1: After reset, status is 0, busy is 0, no read or write beat is offered and the completion pulse is low.
- R2: A write to the control register (cfg_sel = 0) with bit 0 set, made while the channel is idle, arms the channel. On the next clock, status becomes 1 and busy becomes 1. Busy stays high until a terminal status (0, 5 or 6) is reached.
- R3: The trigger select is control bits 20:16. Code 0 starts the channel without waiting. Any other code k waits until evt_in[k] is high. Other evt_in bits do not start it.
- R4: The status encoding is 0 done, 1 waiting for event, 2 event seen, 3 transferring, 4 notifying, 5 cleared and 6 error. A good request passes through 1, 2, 3, 4 and 0. Status 2 lasts exactly one clock, and so does status 4.
- R5: The source register (cfg_sel = 1) holds a block address in bits 31:7 and a target code in bits 1:0. The read address for beat j of block b is (source block + b) * 128 + 4 * j, and beats are issued in increasing order.
- R6: The destination register (cfg_sel = 2) uses the same layout. Every write beat of block b carries the address (destination block + b) * 128. The write data equals the data returned by the matching read.
- R7: A size value N in bits 6:0 of cfg_sel = 3 moves exactly N+1 blocks of 32 beats each.
- R8: The channel is armed only if the source target code is 2 and the destination target code is 1. With any other pair, status goes to 6 on the next clock and no beat is issued.
- R9: Raising clear_all while busy sets status 5 on the next clock. It stops all further beats and raises the completion pulse. When the channel is idle, clear_all has no effect.
- R10: Configuration writes made while busy are ignored. The running request keeps the source, destination, size and trigger it was armed with.
- R11: done_pulse is high for exactly one clock, on entry to status 0, 5 or 6. It fires once per armed request.
- R12: A beat that is not accepted is held. A write beat that is refused keeps the same address and data until wr_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 size |
| cfg_wdata | input | 32 | Configuration write data |
| evt_in | input | 32 | Trigger lines, indexed by trigger code |
| clear_all | input | 1 | Global abort |
| status | output | 3 | Progress code |
| busy | output | 1 | Request bit readback (1 while the request is outstanding) |
| done_pulse | output | 1 | One-clock completion pulse |
| rd_valid | output | 1 | Read beat request |
| rd_addr | output | 32 | Read beat byte address |
| rd_ready | input | 1 | Read beat accepted, with rd_data valid |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | FIFO write beat offered |
| wr_addr | output | 32 | FIFO write block address |
| wr_data | output | 32 | FIFO write data |
| wr_ready | input | 1 | FIFO write beat accepted |

## Verification
The bench runs a transfer with randomized back-pressure on both handshakes, so that a beat counter that advances on a refused beat skips or repeats addresses. It holds unrelated trigger lines high while the channel waits. A decoder that is off by one code, or that treats code 0 as a line, would start early. It rewrites the configuration in the middle of a request and checks that the scoreboard still sees the original addresses and count. A design with unguarded configuration registers would diverge there. It also checks that a bad target pair gives ERROR with no bus activity, and that a clear in the waiting state and a clear mid-transfer each give a single pulse and no further beats. A design that missed either case would keep issuing beats or would give a wrong pulse count.

// File: rtl/audio_dma_channel.sv
module audio_dma_channel #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int EVT_W    = 5,
  parameter int SIZE_W   = 7,
  parameter int BLK_LG   = 7,
  parameter int TGT_W    = 2,
  parameter int SRC_TGT  = 2,
  parameter int DST_TGT  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [31:0]           cfg_wdata,
  input  logic [(1<<EVT_W)-1:0] evt_in,
  input  logic                  clear_all,
  output logic [2:0]            status,
  output logic                  busy,
  output logic                  done_pulse,
  output logic                  rd_valid,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_ready,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  wr_valid,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  input  logic                  wr_ready
);
  localparam int BEAT_LG = $clog2(DATA_W / 8);
  localparam int BEAT_W  = BLK_LG - BEAT_LG;
  localparam int BLK_AW  = ADDR_W - BLK_LG;
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  typedef enum logic [2:0] {
    S_DONE = 3'd0, S_EVENT = 3'd1, S_PEND = 3'd2, S_XFER = 3'd3,
    S_NOTE = 3'd4, S_CLR = 3'd5, S_ERR = 3'd6
  } st_t;

  st_t               state;
  logic [EVT_W-1:0]  evt_sel;
  logic [BLK_AW-1:0] src_blk, dst_blk;
  logic [TGT_W-1:0]  src_tgt, dst_tgt;
  logic [SIZE_W-1:0] size_q, blk_cnt;
  logic [BEAT_W-1:0] beat_cnt;
  logic              wr_phase;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  assign busy = (state == S_EVENT) || (state == S_PEND) ||
                (state == S_XFER) || (state == S_NOTE);
  assign status     = state;
  assign done_pulse = done_q;

  wire cfg_ok   = cfg_we && !busy;
  wire arm      = cfg_ok && (cfg_sel == 2'd0) && cfg_wdata[0];
  wire tgt_good = (src_tgt == TGT_W'(SRC_TGT)) && (dst_tgt == TGT_W'(DST_TGT));
  wire trig     = (evt_sel == '0) || evt_in[evt_sel];
  wire last     = (beat_cnt == LAST_BEAT) && (blk_cnt == size_q);

  wire [BLK_AW-1:0] rd_blk = src_blk + BLK_AW'(blk_cnt);
  wire [BLK_AW-1:0] wr_blk = dst_blk + BLK_AW'(blk_cnt);

  assign rd_valid = (state == S_XFER) && !wr_phase;
  assign wr_valid = (state == S_XFER) && wr_phase;
  assign rd_addr  = {rd_blk, beat_cnt, {BEAT_LG{1'b0}}};
  assign wr_addr  = {wr_blk, {BLK_LG{1'b0}}};
  assign wr_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_blk <= '0; src_tgt <= '0;
      dst_blk <= '0; dst_tgt <= '0;
      size_q  <= '0; evt_sel <= '0;
    end else if (cfg_ok) begin
      case (cfg_sel)
        2'd0: evt_sel <= cfg_wdata[16 +: EVT_W];
        2'd1: begin src_blk <= cfg_wdata[BLK_LG +: BLK_AW]; src_tgt <= cfg_wdata[TGT_W-1:0]; end
        2'd2: begin dst_blk <= cfg_wdata[BLK_LG +: BLK_AW]; dst_tgt <= cfg_wdata[TGT_W-1:0]; end
        default: size_q <= cfg_wdata[SIZE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_DONE;
      blk_cnt  <= '0;
      beat_cnt <= '0;
      wr_phase <= 1'b0;
      data_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy && clear_all) begin
        state  <= S_CLR;
        done_q <= 1'b1;
      end else begin
        case (state)
          S_EVENT: if (trig) state <= S_PEND;
          S_PEND:  state <= S_XFER;
          S_XFER: begin
            if (!wr_phase) begin
              if (rd_ready) begin
                data_q   <= rd_data;
                wr_phase <= 1'b1;
              end
            end else if (wr_ready) begin
              wr_phase <= 1'b0;
              if (last) state <= S_NOTE;
              else begin
                beat_cnt <= beat_cnt + 1'b1;
                if (beat_cnt == LAST_BEAT) blk_cnt <= blk_cnt + 1'b1;
              end
            end
          end
          S_NOTE: begin
            state  <= S_DONE;
            done_q <= 1'b1;
          end
          default: if (arm) begin
            blk_cnt  <= '0;
            beat_cnt <= '0;
            wr_phase <= 1'b0;
            if (tgt_good) state <= S_EVENT;
            else begin
              state  <= S_ERR;
              done_q <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  a_r11_pulse_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (status == 3'd0 || status == 3'd5 || status == 3'd6));
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && clear_all) |=> (status == 3'd5 && done_pulse && !rd_valid && !wr_valid));
  a_r4_pend_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd2 && !clear_all) |=> (status == 3'd3));
  a_r12_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !clear_all) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(src_blk) && $stable(dst_blk) && $stable(size_q) && $stable(evt_sel)));
  a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd6) |-> (!rd_valid && !wr_valid && !busy));
endmodule

// File: tb/test_audio_dma_channel.sv
module test_audio_dma_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] evt_in = '0;
  logic        clear_all = 1'b0;
  logic [2:0]  status;
  logic        busy, done_pulse;
  logic        rd_valid, wr_valid;
  logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
  logic        rd_ready = 1'b1, wr_ready = 1'b1;
  logic        bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, fails = 0, pulses = 0;
  logic [31:0] rdq[$];
  logic [63:0] wrq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data = rd_addr ^ 32'h5A5A_0F0F;

  audio_dma_channel i_audio_dma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .evt_in(evt_in), .clear_all(clear_all), .status(status), .busy(busy),
    .done_pulse(done_pulse), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_xfer(input logic [24:0] sblk, input logic [24:0] dblk, input int n);
    for (int b = 0; b <= n; b++)
      for (int j = 0; j < 32; j++) begin
        logic [31:0] ra;
        ra = {sblk + 25'(b), 7'd0} + 32'(4 * j);
        rdq.push_back(ra);
        wrq.push_back({{dblk + 25'(b), 7'd0}, ra ^ 32'h5A5A_0F0F});
      end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_ready = bp_on ? lfsr[0] : 1'b1;
      wr_ready = bp_on ? (lfsr[3] | lfsr[7]) : 1'b1;
    end
  end

  initial begin
    logic        held = 1'b0, prev_pulse = 1'b0;
    logic [63:0] held_v = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held && wr_valid)
          check({wr_addr, wr_data} == held_v, "R12 held beat", {wr_addr, wr_data}, held_v);
        held = wr_valid && !wr_ready;
        held_v = {wr_addr, wr_data};
        if (rd_valid && rd_ready) begin
          if (rdq.size() == 0) check(1'b0, "R5/R7 unexpected read", rd_addr, 0);
          else begin
            logic [31:0] e;
            e = rdq.pop_front();
            check(rd_addr == e, "R5 read address", rd_addr, e);
          end
        end
        if (wr_valid && wr_ready) begin
          if (wrq.size() == 0) check(1'b0, "R6/R7 unexpected write", wr_addr, 0);
          else begin
            logic [63:0] e;
            e = wrq.pop_front();
            check({wr_addr, wr_data} == e, "R6 write addr/data", {wr_addr, wr_data}, e);
          end
        end
        if (done_pulse) begin
          pulses++;
          check(!prev_pulse, "R11 pulse width", 1, 0);
        end
        prev_pulse = done_pulse;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 3'd0, "R1 status", status, 0);
    check(!busy && !rd_valid && !wr_valid && !done_pulse, "R1 quiet", {busy, rd_valid, wr_valid, done_pulse}, 0);

    // R2/R4 single block, immediate start
    cfg(2'd1, {25'h100, 5'd0, 2'd2});
    cfg(2'd2, {25'h40, 5'd0, 2'd1});
    cfg(2'd3, 32'd0);
    expect_xfer(25'h100, 25'h40, 0);
    cfg(2'd0, 32'h0000_0001);
    check(status == 3'd1 && busy, "R2 armed", {busy, status}, 4'h9);
    @(negedge clk); check(status == 3'd2, "R4 pending", status, 2);
    @(negedge clk); check(status == 3'd3, "R4 transferring", status, 3);
    while (status == 3'd3) @(negedge clk);
    check(status == 3'd4 && busy, "R4 notify", status, 4);
    @(negedge clk);
    check(status == 3'd0 && !busy, "R4 done", status, 0);
    check(rdq.size() == 0 && wrq.size() == 0, "R7 one block moved", rdq.size() + wrq.size(), 0);
    check(pulses == 1, "R11 first pulse", pulses, 1);

    // R5/R6/R7/R12 three blocks with back-pressure
    bp_on = 1'b1;
    cfg(2'd1, {25'h1FF_FFFE, 5'd0, 2'd2});
    cfg(2'd2, {25'h0A0, 5'd0, 2'd1});
    cfg(2'd3, 32'd2);
    expect_xfer(25'h1FF_FFFE, 25'h0A0, 2);
    cfg(2'd0, 32'h0000_0001);
    wait_idle();
    @(negedge clk);
    check(status == 3'd0 && rdq.size() == 0 && wrq.size() == 0, "R7 three blocks", rdq.size() + wrq.size(), 0);
    check(pulses == 2, "R11 second pulse", pulses, 2);

    // R3/R10 trigger wait, config written while busy is ignored
    cfg(2'd1, {25'h300, 5'd0, 2'd2});
    cfg(2'd2, {25'h010, 5'd0, 2'd1});
    cfg(2'd3, 32'd1);
    expect_xfer(25'h300, 25'h010, 1);
    cfg(2'd0, (32'd5 << 16) | 32'd1);
    evt_in = 32'h0000_0041;
    cfg(2'd1, {25'h777, 5'd0, 2'd2});
    cfg(2'd3, 32'd5);
    cfg(2'd0, 32'h0000_0001);
    repeat (6) @(negedge clk);
    check(status == 3'd1, "R3 other lines ignored", status, 1);
    evt_in = 32'h0000_0020;
    @(negedge clk);
    check(status == 3'd2, "R3 selected line starts", status, 2);
    evt_in = '0;
    wait_idle();
    @(negedge clk);
    check(rdq.size() == 0 && wrq.size() == 0, "R10 original config used", rdq.size() + wrq.size(), 0);
    bp_on = 1'b0;

    // R8 bad source target, then bad destination target
    p0 = pulses;
    cfg(2'd1, {25'h300, 5'd0, 2'd3});
    cfg(2'd0, 32'h0000_0001);
    check(status == 3'd6 && !busy, "R8 bad source", status, 6);
    cfg(2'd1, {25'h300, 5'd0, 2'd2});
    cfg(2'd2, {25'h010, 5'd0, 2'd2});
    cfg(2'd0, 32'h0000_0001);
    check(status == 3'd6 && !busy, "R8 bad destination", status, 6);
    repeat (5) @(negedge clk);
    check(pulses == p0 + 2, "R8 error pulses", pulses, p0 + 2);

    // R9 clear while idle, while waiting, and mid-transfer
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    check(status == 3'd6 && pulses == p0 + 2, "R9 idle clear no effect", status, 6);
    cfg(2'd2, {25'h010, 5'd0, 2'd1});
    cfg(2'd0, (32'd9 << 16) | 32'd1);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    check(status == 3'd5 && !busy, "R9 clear while waiting", status, 5);
    check(pulses == p0 + 3, "R9 pulse on clear", pulses, p0 + 3);
    bp_on = 1'b1;
    cfg(2'd3, 32'd3);
    expect_xfer(25'h300, 25'h010, 3);
    cfg(2'd0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    check(status == 3'd3, "R9 running before clear", status, 3);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
    check(status == 3'd5 && !busy && !rd_valid && !wr_valid, "R9 clear mid-transfer", status, 5);
    rdq.delete(); wrq.delete();
    repeat (30) @(negedge clk);
    check(pulses == p0 + 4, "R11 total pulses", pulses, p0 + 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule